// File: doc/BRIEF.md
# Audio FIFO Status and Request Controller

This block holds one 32-word audio sample FIFO and the status logic that decides when software or a DMA engine should service it. The same block serves either direction. In transmit mode the host side pushes samples and the serializer pops them. In receive mode the deserializer pushes and the host side pops.

It keeps the FIFO read and write pointers, each with one extra wrap bit, so the fill level can be recovered from them. From that level it derives a live request condition and a live warning condition. It also collects three sticky event flags: FIFO error, framing sync error and word start. Each condition has its own interrupt enable. The request and warning conditions also have their own DMA enables. A single control word carries the enables, a watermark, a soft-reset bit, write-1-to-clear bits and a one-shot FIFO flush.

Top module: `audio_fifo_status`

## Requirements
- R1: After reset both pointers are 0, and the enables, watermark, soft-reset bit and sticky flags are 0. In transmit mode `ctl_rdata` reads 0x00000300, and `irq`, `dma_req` and `dma_warn` are low.
- R2: The FIFO returns samples in push order. The pointers are 6 bits wide and wrap modulo 64. The level is `wr_ptr - rd_ptr` and never exceeds 32. A push into a full FIFO and a pop from an empty FIFO leave the pointers unchanged.
- R3: The request flag (`ctl_rdata` bit 8) is 1 in transmit mode when level ≤ watermark, and 1 in receive mode when level > watermark.
- R4: The warning flag (bit 9) is 1 when the FIFO is empty in transmit mode, or full (level 32) in receive mode.
- R5: The error flag (bit 10) becomes 1 and stays 1 after a pop from an empty FIFO in transmit mode, or after a push into a full FIFO in receive mode. A full push in transmit mode does not set it, and an empty pop in receive mode does not set it.
- R6: A pulse on `sync_evt` sets the sticky sync flag (bit 11). A pulse on `word_evt` sets the sticky word flag (bit 12).
- R7: Writing 1 to bit 10, 11 or 12 of the control word clears that sticky flag. If a new event arrives in the same cycle as the clear, the flag stays set.
- R8: `irq` is the OR of each flag ANDed with its enable. The interrupt enables are: bit 2 for request, bit 3 for warning, bit 4 for error, bit 5 for sync and bit 6 for word.
- R9: `dma_req` is the request flag AND enable bit 0. `dma_warn` is the warning flag AND enable bit 1.
- R10: Writing 1 to bit 13 sets both pointers to 0 on that edge and leaves the sticky flags unchanged. Bit 13 always reads back as 0.
- R11: While soft-reset bit 7 is 1, the pointers are held at 0, pushes are ignored and the sticky flags are cleared. The enables and the watermark keep their values.
- R12: The watermark is written in bits 20:16 and reads back in the same bits. Bits 6:0 read back the enables. Bit 7 reads back the soft-reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_mode | input | 1 | 1 = receive direction, 0 = transmit direction |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word |
| ctl_rdata | output | 32 | Readback of enables, soft reset, flags and watermark |
| push | input | 1 | Write one sample into the FIFO |
| push_data | input | 24 | Sample to write |
| pop | input | 1 | Remove the head sample |
| pop_data | output | 24 | Head sample (show-ahead) |
| sync_evt | input | 1 | Frame sync error pulse from the framing logic |
| word_evt | input | 1 | Word start pulse from the framing logic |
| wr_ptr | output | 6 | Write pointer with wrap bit |
| rd_ptr | output | 6 | Read pointer with wrap bit |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | Watermark DMA request |
| dma_warn | output | 1 | Empty/full DMA request |

## Verification
The main stimulus is a table of fills and watermarks run in both directions. It includes levels just at the watermark and one above it, and the empty and full extremes. These points separate the "≤" compare used in transmit mode from the ">" compare used in receive mode, and the empty test from the full test for warning. Directed patterns then do the following:
- An empty pop and a full push in each mode, which shows that only the mode-matching case raises the error flag.
- A clear and an event landing in the same cycle.
- Enables set one at a time, which separates each interrupt term.
- Long push/pop runs, which cross the pointer wrap.
- A soft reset issued with a full configuration, which separates what is cleared from what is kept.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  // control word field positions
  localparam int EN_REQ_DMA  = 0;
  localparam int EN_WARN_DMA = 1;
  localparam int EN_W        = 7;
  localparam int SRST_BIT    = 7;
  localparam int FLG_REQ     = 8;
  localparam int FLG_WARN    = 9;
  localparam int FLG_ERR     = 10;
  localparam int FLG_SYNC    = 11;
  localparam int FLG_WORD    = 12;
  localparam int FLUSH_BIT   = 13;
  localparam int WM_LSB      = 16;
  localparam int WM_W        = 5;

  // packed so that req_dma lands on bit 0
  typedef struct packed {
    logic word_irq;
    logic sync_irq;
    logic err_irq;
    logic warn_irq;
    logic req_irq;
    logic warn_dma;
    logic req_dma;
  } en_t;

  typedef struct packed {
    logic word;
    logic sync;
    logic err;
  } sticky_t;
endpackage

// File: rtl/afs_fifo_core.sv
module afs_fifo_core #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hold,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              push_rej,
  output logic              pop_rej
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic              push_ok, pop_ok;

  assign level    = wr_q - rd_q;
  assign full     = (level == PTR_W'(DEPTH));
  assign empty    = (level == '0);
  assign push_ok  = push & ~full & ~hold;
  assign pop_ok   = pop & ~empty & ~hold;
  assign push_rej = push & full & ~hold;
  assign pop_rej  = pop & empty & ~hold;

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (clr) begin
      wr_d = '0;
      rd_d = '0;
    end else begin
      if (push_ok) wr_d = wr_q + 1'b1;
      if (pop_ok)  rd_d = rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  // sample storage, not reset
  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q[IDX_W-1:0]] <= push_data;
  end

  assign pop_data = mem[rd_q[IDX_W-1:0]];
  assign wr_ptr   = wr_q;
  assign rd_ptr   = rd_q;
endmodule

// File: rtl/afs_ctl_regs.sv
module afs_ctl_regs
  import audio_fifo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic [31:0]     ctl_wdata,
  input  logic            err_evt,
  input  logic            sync_evt,
  input  logic            word_evt,
  output en_t             en,
  output logic [WM_W-1:0] wm,
  output logic            srst,
  output logic            hold,
  output logic            flush,
  output sticky_t         sticky
);
  en_t             en_q, en_d;
  logic [WM_W-1:0] wm_q, wm_d;
  logic            srst_q, srst_d;
  sticky_t         st_q, st_d, st_set, st_clr;
  logic            unused_wbits;

  assign unused_wbits = ^{ctl_wdata[31:WM_LSB+WM_W], ctl_wdata[WM_LSB-1:FLUSH_BIT+1],
                          ctl_wdata[FLG_WARN:FLG_REQ]};

  assign flush  = ctl_wr & ctl_wdata[FLUSH_BIT];
  assign hold   = srst_q | (ctl_wr & ctl_wdata[SRST_BIT]);
  assign st_set = '{word: word_evt, sync: sync_evt, err: err_evt};
  assign st_clr = ctl_wr ? '{word: ctl_wdata[FLG_WORD], sync: ctl_wdata[FLG_SYNC],
                             err: ctl_wdata[FLG_ERR]} : '0;

  always_comb begin
    en_d   = en_q;
    wm_d   = wm_q;
    srst_d = srst_q;
    if (ctl_wr) begin
      en_d   = en_t'(ctl_wdata[EN_W-1:0]);
      wm_d   = ctl_wdata[WM_LSB +: WM_W];
      srst_d = ctl_wdata[SRST_BIT];
    end
    // a new event wins over a clear in the same cycle
    if (hold) st_d = '0;
    else      st_d = (st_q & ~st_clr) | st_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      wm_q   <= '0;
      srst_q <= 1'b0;
      st_q   <= '0;
    end else begin
      en_q   <= en_d;
      wm_q   <= wm_d;
      srst_q <= srst_d;
      st_q   <= st_d;
    end
  end

  assign en     = en_q;
  assign wm     = wm_q;
  assign srst   = srst_q;
  assign sticky = st_q;
endmodule

// File: rtl/afs_req_gen.sv
module afs_req_gen
  import audio_fifo_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             rx_mode,
  input  logic [PTR_W-1:0] level,
  input  logic             full,
  input  logic             empty,
  input  logic [WM_W-1:0]  wm,
  input  en_t              en,
  input  sticky_t          sticky,
  output logic             req_flag,
  output logic             warn_flag,
  output logic             irq,
  output logic             dma_req,
  output logic             dma_warn
);
  logic [PTR_W-1:0] wm_ext;
  logic [4:0]       flags, irq_en;

  assign wm_ext    = PTR_W'(wm);
  assign req_flag  = rx_mode ? (level > wm_ext) : (level <= wm_ext);
  assign warn_flag = rx_mode ? full : empty;

  assign flags  = {sticky.word, sticky.sync, sticky.err, warn_flag, req_flag};
  assign irq_en = {en.word_irq, en.sync_irq, en.err_irq, en.warn_irq, en.req_irq};

  assign irq      = |(flags & irq_en);
  assign dma_req  = req_flag & en.req_dma;
  assign dma_warn = warn_flag & en.warn_dma;
endmodule

// File: rtl/audio_fifo_status.sv
module audio_fifo_status
  import audio_fifo_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  input  logic              sync_evt,
  input  logic              word_evt,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              irq,
  output logic              dma_req,
  output logic              dma_warn
);
  logic [1:0]       rst_sync;
  logic             core_rst_n;
  en_t              en;
  logic [WM_W-1:0]  wm;
  logic             srst, hold, flush;
  sticky_t          sticky;
  logic [PTR_W-1:0] level;
  logic             full, empty, push_rej, pop_rej, err_evt;
  logic             req_flag, warn_flag;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  assign err_evt = rx_mode ? push_rej : pop_rej;

  afs_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_wdata(ctl_wdata),
    .err_evt  (err_evt),
    .sync_evt (sync_evt),
    .word_evt (word_evt),
    .en       (en),
    .wm       (wm),
    .srst     (srst),
    .hold     (hold),
    .flush    (flush),
    .sticky   (sticky)
  );

  afs_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clr      (flush | hold),
    .hold     (hold),
    .push     (push),
    .push_data(push_data),
    .pop      (pop),
    .pop_data (pop_data),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .level    (level),
    .full     (full),
    .empty    (empty),
    .push_rej (push_rej),
    .pop_rej  (pop_rej)
  );

  afs_req_gen #(.PTR_W(PTR_W)) u_req (
    .rx_mode  (rx_mode),
    .level    (level),
    .full     (full),
    .empty    (empty),
    .wm       (wm),
    .en       (en),
    .sticky   (sticky),
    .req_flag (req_flag),
    .warn_flag(warn_flag),
    .irq      (irq),
    .dma_req  (dma_req),
    .dma_warn (dma_warn)
  );

  always_comb begin
    ctl_rdata               = '0;
    ctl_rdata[EN_W-1:0]     = en;
    ctl_rdata[SRST_BIT]     = srst;
    ctl_rdata[FLG_REQ]      = req_flag;
    ctl_rdata[FLG_WARN]     = warn_flag;
    ctl_rdata[FLG_ERR]      = sticky.err;
    ctl_rdata[FLG_SYNC]     = sticky.sync;
    ctl_rdata[FLG_WORD]     = sticky.word;
    ctl_rdata[WM_LSB +: WM_W] = wm;
  end
endmodule

// File: rtl/audio_fifo_status_chk.sv
module audio_fifo_status_chk
  import audio_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_mode,
  input logic             ctl_wr,
  input logic [31:0]      ctl_wdata,
  input logic [31:0]      ctl_rdata,
  input logic             push,
  input logic             pop,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             irq,
  input logic             dma_req,
  input logic             dma_warn
);
  logic [PTR_W-1:0] lvl;
  assign lvl = wr_ptr - rd_ptr;

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= PTR_W'(DEPTH));

  p_full_push_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !ctl_wr && lvl == PTR_W'(DEPTH)) |=> $stable(wr_ptr));

  p_warn_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[FLG_WARN] |-> (rx_mode ? (lvl == PTR_W'(DEPTH)) : (lvl == '0)));

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[FLG_ERR]) |->
      $past((!rx_mode && pop && lvl == '0) || (rx_mode && push && lvl == PTR_W'(DEPTH))));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6:2] == 5'b0) |-> !irq);

  p_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req |-> ctl_rdata[EN_REQ_DMA]) and (dma_warn |-> ctl_rdata[EN_WARN_DMA]));

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[FLUSH_BIT]) |=> (wr_ptr == '0 && rd_ptr == '0));

  p_srst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[SRST_BIT] |-> (wr_ptr == '0 && rd_ptr == '0 && ctl_rdata[FLG_WORD:FLG_ERR] == 3'b0));
endmodule

bind audio_fifo_status audio_fifo_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_mode  (rx_mode),
  .ctl_wr   (ctl_wr),
  .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata),
  .push     (push),
  .pop      (pop),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr),
  .irq      (irq),
  .dma_req  (dma_req),
  .dma_warn (dma_warn)
);

// File: tb/audio_fifo_status_tb.sv
module audio_fifo_status_tb;
  localparam int DATA_W = 24;
  localparam int DEPTH  = 32;
  localparam int PTR_W  = 6;

  logic              clk, rst_n, rx_mode, ctl_wr, push, pop, sync_evt, word_evt;
  logic [31:0]       ctl_wdata, ctl_rdata;
  logic [DATA_W-1:0] push_data, pop_data;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              irq, dma_req, dma_warn;

  int  errs = 0;
  int  checks = 0;
  bit  done = 0;

  audio_fifo_status #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .push(push),
    .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .sync_evt(sync_evt), .word_evt(word_evt), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .irq(irq), .dma_req(dma_req), .dma_warn(dma_warn)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {rx_mode, fill[5:0], wm[4:0], exp_req, exp_warn}
  localparam int NVEC = 11;
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 6'd0,  5'd0,  1'b1, 1'b1},
    {1'b0, 6'd5,  5'd4,  1'b0, 1'b0},
    {1'b0, 6'd4,  5'd4,  1'b1, 1'b0},
    {1'b0, 6'd32, 5'd31, 1'b0, 1'b0},
    {1'b0, 6'd31, 5'd31, 1'b1, 1'b0},
    {1'b1, 6'd0,  5'd0,  1'b0, 1'b0},
    {1'b1, 6'd1,  5'd0,  1'b1, 1'b0},
    {1'b1, 6'd8,  5'd8,  1'b0, 1'b0},
    {1'b1, 6'd9,  5'd8,  1'b1, 1'b0},
    {1'b1, 6'd32, 5'd31, 1'b1, 1'b1},
    {1'b1, 6'd32, 5'd0,  1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [6:0] en, input logic [4:0] wm,
                                     input logic [31:0] extra);
    return {11'b0, wm, 16'b0} | {25'b0, en} | extra;
  endfunction

  task automatic ctl(input logic [31:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic do_push(input logic [DATA_W-1:0] d);
    @(negedge clk); push = 1'b1; push_data = d;
    @(negedge clk); push = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_mode = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0;
    push = 1'b0; push_data = '0; pop = 1'b0; sync_evt = 1'b0; word_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", ctl_rdata, 32'h0000_0300);
    chk("R1 ptrs", {26'b0, wr_ptr}, 32'd0);
    chk("R1 rd ptr", {26'b0, rd_ptr}, 32'd0);
    chk("R1 outputs", {29'b0, irq, dma_req, dma_warn}, 32'd0);

    // R3 R4 R9 table of fill and watermark in both directions
    for (int i = 0; i < NVEC; i++) begin
      logic       m, er, ew;
      logic [5:0] fill;
      logic [4:0] wm;
      {m, fill, wm, er, ew} = VEC[i];
      rx_mode = m;
      ctl(cw(7'h03, wm, 32'h2000));
      for (int k = 0; k < int'(fill); k++) do_push(DATA_W'(k));
      chk($sformatf("R3 req vec%0d", i), {31'b0, ctl_rdata[8]}, {31'b0, er});
      chk($sformatf("R4 warn vec%0d", i), {31'b0, ctl_rdata[9]}, {31'b0, ew});
      chk($sformatf("R9 dma vec%0d", i), {30'b0, dma_req, dma_warn}, {30'b0, er, ew});
      chk($sformatf("R2 level vec%0d", i), {26'b0, wr_ptr - rd_ptr}, {26'b0, fill});
    end

    // R2 order
    rx_mode = 1'b0;
    ctl(cw(7'h00, 5'd0, 32'h2000));
    do_push(24'hA1A1A1); do_push(24'hB2B2B2); do_push(24'hC3C3C3);
    chk("R2 head0", {8'b0, pop_data}, 32'h00A1A1A1); do_pop();
    chk("R2 head1", {8'b0, pop_data}, 32'h00B2B2B2); do_pop();
    chk("R2 head2", {8'b0, pop_data}, 32'h00C3C3C3); do_pop();

    // R2 wrap: 3 + 67 pairs = 70 -> 6 mod 64
    for (int k = 0; k < 67; k++) begin do_push(DATA_W'(k)); do_pop(); end
    chk("R2 wrap wr", {26'b0, wr_ptr}, 32'd6);
    chk("R2 wrap rd", {26'b0, rd_ptr}, 32'd6);

    // R5 transmit underrun, R8 error irq
    ctl(cw(7'h10, 5'd0, 32'h2000));
    chk("R8 no irq before err", {31'b0, irq}, 32'd0);
    do_pop();
    chk("R5 tx underrun", {31'b0, ctl_rdata[10]}, 32'd1);
    chk("R2 empty pop holds", {26'b0, rd_ptr}, 32'd0);
    chk("R8 err irq", {31'b0, irq}, 32'd1);
    // R7 set wins over clear
    @(negedge clk); pop = 1'b1; ctl_wr = 1'b1; ctl_wdata = cw(7'h10, 5'd0, 32'h0400);
    @(negedge clk); pop = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0;
    chk("R7 set beats clear", {31'b0, ctl_rdata[10]}, 32'd1);
    ctl(cw(7'h10, 5'd0, 32'h0400));
    chk("R7 clear err", {31'b0, ctl_rdata[10]}, 32'd0);
    // R5 full push in transmit: no error
    for (int k = 0; k < 33; k++) do_push(DATA_W'(k));
    chk("R2 full push holds", {26'b0, wr_ptr}, 32'd32);
    chk("R5 tx full push no err", {31'b0, ctl_rdata[10]}, 32'd0);

    // R5 receive overflow
    rx_mode = 1'b1;
    ctl(cw(7'h00, 5'd0, 32'h2000));
    for (int k = 0; k < 32; k++) do_push(DATA_W'(k));
    chk("R5 rx full no err yet", {31'b0, ctl_rdata[10]}, 32'd0);
    do_push(24'h0);
    chk("R5 rx overflow", {31'b0, ctl_rdata[10]}, 32'd1);
    chk("R2 rx overflow wr", {26'b0, wr_ptr}, 32'd32);
    // R10 flush keeps sticky, reads 0
    ctl(cw(7'h00, 5'd0, 32'h2000));
    chk("R10 flush ptrs", {20'b0, wr_ptr, rd_ptr}, 32'd0);
    chk("R10 flush keeps err", {31'b0, ctl_rdata[10]}, 32'd1);
    chk("R10 flush reads 0", {31'b0, ctl_rdata[13]}, 32'd0);
    ctl(cw(7'h00, 5'd0, 32'h0400));
    do_pop();
    chk("R5 rx empty pop no err", {31'b0, ctl_rdata[10]}, 32'd0);

    // R6 R8 sync and word events, irq per enable
    ctl(cw(7'h40, 5'd0, 32'h0));
    @(negedge clk); sync_evt = 1'b1; @(negedge clk); sync_evt = 1'b0;
    chk("R6 sync flag", {31'b0, ctl_rdata[11]}, 32'd1);
    chk("R8 sync masked", {31'b0, irq}, 32'd0);
    @(negedge clk); word_evt = 1'b1; @(negedge clk); word_evt = 1'b0;
    chk("R6 word flag", {31'b0, ctl_rdata[12]}, 32'd1);
    chk("R8 word irq", {31'b0, irq}, 32'd1);
    ctl(cw(7'h40, 5'd0, 32'h1000));
    chk("R7 clear word", {30'b0, ctl_rdata[12:11]}, 32'd1);
    chk("R8 irq drops", {31'b0, irq}, 32'd0);
    ctl(cw(7'h40, 5'd0, 32'h0800));
    chk("R7 clear sync", {31'b0, ctl_rdata[11]}, 32'd0);

    // R11 R12 soft reset keeps config
    rx_mode = 1'b0;
    ctl(cw(7'h7F, 5'd7, 32'h2000));
    chk("R12 wm readback", {27'b0, ctl_rdata[20:16]}, 32'd7);
    for (int k = 0; k < 5; k++) do_push(DATA_W'(k));
    for (int k = 0; k < 6; k++) do_pop();
    do_push(24'h5); do_push(24'h6);
    chk("R5 err before srst", {31'b0, ctl_rdata[10]}, 32'd1);
    ctl(cw(7'h7F, 5'd7, 32'h0080));
    chk("R11 srst rdata", ctl_rdata, 32'h0007_03FF);
    chk("R11 srst ptrs", {20'b0, wr_ptr, rd_ptr}, 32'd0);
    do_push(24'h9);
    chk("R11 push ignored", {26'b0, wr_ptr}, 32'd0);
    ctl(cw(7'h7F, 5'd7, 32'h0));
    do_push(24'h9);
    chk("R11 release push", {26'b0, wr_ptr}, 32'd1);
    chk("R12 cfg kept", {24'b0, ctl_rdata[7:0]}, 32'h7F);

    finish_run();
  end
endmodule